// File: doc/BRIEF.md
# Configurable Serial Character Transmitter

This block sends one character at a time on a serial data line. An 8-bit mode register sets the framing. A host can write and read that register on any cycle. When the host raises a start pulse while the block is ready, the block captures the character byte and the current mode settings, then shifts the frame out. Register writes made after that point wait for the next frame.

There are two framings. In asynchronous mode each frame has a low start bit, then 7 or 8 data bits sent LSB first, then an optional even or odd parity bit, then one or two high stop bits. In clocked synchronous mode the frame is always 8 data bits sent LSB first, with a shift clock output. Data changes on the falling edge of that clock and holds steady across its rising edge.

A prescaler divides the system clock by 1, 4, 16 or 64. Every bit then lasts `2*HALF_TICKS` prescaled ticks.

Top module: `ser_tx_top`

## Requirements
- R1: The mode register takes `reg_wdata_i` on any cycle with `reg_we_i` high and `standby_i` low, and `reg_rdata_o` shows its value. Bit 7 is mode (0 async, 1 sync), bit 6 is short character (1 = 7 data bits), bit 5 is parity enable, bit 4 is parity sense (0 even, 1 odd), bit 3 is two-stop, bit 2 is stored only, and bits 1:0 are the clock divide select.
- R2: The mode register clears to 0x00 on reset, and in any cycle that `standby_i` is high.
- R3: An async frame begins with a low start bit. The data bits follow LSB first, and the frame ends with high stop bits. `txd_o` sits high whenever no frame is in progress.
- R4: In async mode with bit 6 set, only data bits 0 to 6 are sent, and bit 7 of the captured byte never reaches the line.
- R5: In async mode with bit 5 set, one parity bit follows the data bits that were sent. It makes the total count of ones even when bit 4 is 0, and odd when bit 4 is 1.
- R6: In async mode, bit 3 = 0 gives one stop bit and bit 3 = 1 gives two. `ready_o` returns high exactly when the last stop bit ends.
- R7: In sync mode the frame is exactly 8 data bits, LSB first, with no start, parity or stop bit, whatever bits 6 and 5 hold. During each bit `sck_o` is low for the first half and high for the second.
- R8: Every bit lasts `2*HALF_TICKS*D` clock cycles, where D is 1, 4, 16 or 64 for a select value of 0, 1, 2 or 3.
- R9: `ready_o` is high while idle and drops on the cycle after a start is accepted. A start pulse while busy is ignored. Mode writes and character changes during a frame do not change that frame.
- R10: `sck_o` stays high whenever a synchronous frame is not being shifted, which includes every async frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| standby_i | input | 1 | Clears the mode register while high |
| reg_we_i | input | 1 | Mode register write strobe |
| reg_wdata_i | input | 8 | Mode register write value |
| reg_rdata_o | output | 8 | Mode register read value |
| tx_data_i | input | 8 | Character to transmit |
| start_i | input | 1 | Start request, accepted while ready |
| ready_o | output | 1 | High when idle |
| txd_o | output | 1 | Serial data line |
| sck_o | output | 1 | Synchronous shift clock |

## Verification
The bench sends frames under several mode patterns:
- Plain 8-bit async.
- 7-bit characters with bit 7 set, which shows whether the top bit leaks onto the line.
- Even and odd parity on the same byte, which tells the two senses apart.
- One and two stop bits, which differ only in when `ready_o` returns.
- Sync mode with the length and parity bits set, which shows they are ignored.

It also runs frames at divides of 4 and 64 to confirm that bit timing scales. In one frame the bench writes a new mode and new data mid-frame while pulsing start, and checks that the frame in flight does not change.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef struct packed {
    logic       sync_mode;
    logic       len7;
    logic       par_en;
    logic       par_odd;
    logic       stop2;
    logic       mp;
    logic [1:0] clk_sel;
  } mode_t;

  localparam int unsigned FRAME_W = 12;
  localparam int unsigned LEN_W   = 4;
endpackage

// File: rtl/sertx_mode_reg.sv
module sertx_mode_reg
  import sertx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       standby_i,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output mode_t      mode_o
);
  mode_t q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q <= '0;
    else if (standby_i) q <= '0;
    else if (we_i)      q <= mode_t'(wdata_i);
  end
  assign mode_o = q;
endmodule

// File: rtl/sertx_prescale.sv
module sertx_prescale #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned MAX_SH = 2 * ((1 << SEL_W) - 1);
  localparam int unsigned CNT_W  = (MAX_SH > 0) ? MAX_SH : 1;

  logic [CNT_W:0]   div;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  // divide = 4^sel
  assign div    = (CNT_W+1)'(1) << {sel_i, 1'b0};
  assign lim    = CNT_W'(div - 1'b1);
  assign tick_o = en_i && (cnt == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt <= '0;
    else if (!en_i)  cnt <= '0;
    else if (tick_o) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
  import sertx_pkg::*;
(
  input  mode_t              mode_i,
  input  logic [7:0]         data_i,
  output logic [FRAME_W-1:0] bits_o,
  output logic [LEN_W-1:0]   len_o
);
  logic [LEN_W-1:0] nd;
  logic [7:0]       deff;
  logic             par;

  always_comb begin
    bits_o = '1;
    nd     = mode_i.len7 ? LEN_W'(7) : LEN_W'(8);
    deff   = mode_i.len7 ? {1'b0, data_i[6:0]} : data_i;
    par    = (^deff) ^ mode_i.par_odd;
    if (mode_i.sync_mode) begin
      bits_o[7:0] = data_i;
      len_o       = LEN_W'(8);
    end else begin
      bits_o[0] = 1'b0;
      for (int i = 0; i < 8; i++) begin
        if (i < int'(nd)) bits_o[i+1] = data_i[i];
      end
      if (mode_i.par_en) bits_o[nd+LEN_W'(1)] = par;
      // unused high positions stay 1 and act as stop bits
      len_o = LEN_W'(2) + nd + LEN_W'(mode_i.par_en) + LEN_W'(mode_i.stop2);
    end
  end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
#(
  parameter int unsigned HALF_TICKS = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  mode_t              mode_i,
  input  logic [FRAME_W-1:0] bits_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               tick_i,
  output logic               busy_o,
  output logic [1:0]         sel_o,
  output logic               txd_o,
  output logic               sck_o
);
  localparam int unsigned BIT_T = 2 * HALF_TICKS;
  localparam int unsigned TW    = (BIT_T > 2) ? $clog2(BIT_T) : 1;

  logic               busy, sync_q;
  logic [1:0]         sel_q;
  logic [FRAME_W-1:0] sh;
  logic [LEN_W-1:0]   left;
  logic [TW-1:0]      tcnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy   <= 1'b0;
      sync_q <= 1'b0;
      sel_q  <= '0;
      sh     <= '1;
      left   <= '0;
      tcnt   <= '0;
    end else if (!busy) begin
      if (start_i) begin
        busy   <= 1'b1;
        sync_q <= mode_i.sync_mode;
        sel_q  <= mode_i.clk_sel;
        sh     <= bits_i;
        left   <= len_i;
        tcnt   <= '0;
      end
    end else if (tick_i) begin
      if (tcnt == TW'(BIT_T - 1)) begin
        tcnt <= '0;
        if (left == LEN_W'(1)) busy <= 1'b0;
        else begin
          sh   <= {1'b1, sh[FRAME_W-1:1]};
          left <= left - 1'b1;
        end
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  assign busy_o = busy;
  assign sel_o  = sel_q;
  assign txd_o  = busy ? sh[0] : 1'b1;
  assign sck_o  = !(busy && sync_q && (tcnt < TW'(HALF_TICKS)));
endmodule

// File: rtl/ser_tx_top.sv
module ser_tx_top
  import sertx_pkg::*;
#(
  parameter int unsigned HALF_TICKS = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       standby_i,
  input  logic       reg_we_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic [7:0] tx_data_i,
  input  logic       start_i,
  output logic       ready_o,
  output logic       txd_o,
  output logic       sck_o
);
  mode_t              mode;
  logic [FRAME_W-1:0] bits;
  logic [LEN_W-1:0]   len;
  logic               busy, tick;
  logic [1:0]         sel;

  sertx_mode_reg i_mode (
    .clk_i, .rst_ni, .standby_i,
    .we_i(reg_we_i), .wdata_i(reg_wdata_i), .mode_o(mode)
  );

  sertx_framer i_framer (
    .mode_i(mode), .data_i(tx_data_i), .bits_o(bits), .len_o(len)
  );

  sertx_prescale #(.SEL_W(2)) i_presc (
    .clk_i, .rst_ni, .en_i(busy), .sel_i(sel), .tick_o(tick)
  );

  sertx_shifter #(.HALF_TICKS(HALF_TICKS)) i_shift (
    .clk_i, .rst_ni, .start_i, .mode_i(mode), .bits_i(bits), .len_i(len),
    .tick_i(tick), .busy_o(busy), .sel_o(sel), .txd_o, .sck_o
  );

  assign reg_rdata_o = mode;
  assign ready_o     = !busy;
endmodule

// File: rtl/ser_tx_chk.sv
module ser_tx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       standby_i,
  input logic       reg_we_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       start_i,
  input logic       ready_o,
  input logic       txd_o,
  input logic       sck_o
);
  p_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && !standby_i |=> reg_rdata_o == $past(reg_wdata_i));

  p_standby_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> reg_rdata_o == 8'h00);

  p_idle_line_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> txd_o);

  p_start_bit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && ready_o && !reg_rdata_o[7] |=> !txd_o);

  p_take_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && ready_o |=> !ready_o);

  p_sck_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> sck_o);

  p_sync_first_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && ready_o && reg_rdata_o[7] |=> !sck_o);
endmodule

bind ser_tx_top ser_tx_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .standby_i(standby_i), .reg_we_i(reg_we_i),
  .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .start_i(start_i),
  .ready_o(ready_o), .txd_o(txd_o), .sck_o(sck_o)
);

// File: tb/test_ser_tx_top.sv
module test_ser_tx_top;
  localparam int HALF = 2;

  logic       clk_i = 1'b0, rst_ni = 1'b0, standby_i = 1'b0;
  logic       reg_we_i = 1'b0, start_i = 1'b0;
  logic [7:0] reg_wdata_i = '0, tx_data_i = '0;
  logic [7:0] reg_rdata_o;
  logic       ready_o, txd_o, sck_o;
  int         n_cmp = 0, n_err = 0;
  bit         done = 1'b0;

  always #4 clk_i = ~clk_i;

  ser_tx_top #(.HALF_TICKS(HALF)) i_ser_tx_top (
    .clk_i, .rst_ni, .standby_i, .reg_we_i, .reg_wdata_i, .reg_rdata_o,
    .tx_data_i, .start_i, .ready_o, .txd_o, .sck_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // advance n edges; one-cycle pulses drop after each edge
  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk_i); #1;
      start_i  = 1'b0;
      reg_we_i = 1'b0;
      standby_i = 1'b0;
    end
  endtask

  task automatic wr_mode(input logic [7:0] m);
    reg_we_i = 1'b1; reg_wdata_i = m;
    step(1);
  endtask

  function automatic void exp_frame(input logic [7:0] m, input logic [7:0] d,
                                    output logic [11:0] v, output int len);
    int nd, ones, k;
    v = '1;
    if (m[7]) begin
      v[7:0] = d; len = 8;
    end else begin
      nd = m[6] ? 7 : 8;
      ones = 0;
      k = 0;
      v[k++] = 1'b0;
      for (int i = 0; i < nd; i++) begin v[k++] = d[i]; ones += d[i]; end
      if (m[5]) v[k++] = (m[4] ? ((ones % 2) == 0) : ((ones % 2) == 1));
      len = k + (m[3] ? 2 : 1);
    end
  endfunction

  task automatic run_frame(input string req, input logic [7:0] m, input logic [7:0] d,
                           input bit mid, input logic [7:0] m2, input logic [7:0] d2);
    logic [11:0] v;
    int len, b;
    exp_frame(m, d, v, len);
    b = 2 * HALF * (1 << (2 * m[1:0]));
    wr_mode(m);
    tx_data_i = d; start_i = 1'b1;
    step(1);
    for (int i = 0; i < len; i++) begin
      step(b / 4);
      chk({req, " sck first half"}, sck_o, m[7] ? 1'b0 : 1'b1);
      step(b / 4);
      chk({req, " txd"}, txd_o, v[i]);
      chk({req, " busy"}, ready_o, 1'b0);
      if (mid && i == 0) begin
        reg_we_i = 1'b1; reg_wdata_i = m2; tx_data_i = d2; start_i = 1'b1;
      end
      step(b / 4);
      chk({req, " sck second half"}, sck_o, 1'b1);
      step(b / 4);
    end
    chk({req, " ready at end"}, ready_o, 1'b1);
    chk({req, " idle line"}, txd_o, 1'b1);
    if (mid) chk("R1 mid write kept", reg_rdata_o, m2);
  endtask

  task automatic t_reset;
    chk("R2 reset reg", reg_rdata_o, 8'h00);
    chk("R9 reset ready", ready_o, 1'b1);
    chk("R3 reset line", txd_o, 1'b1);
    chk("R10 reset sck", sck_o, 1'b1);
  endtask

  task automatic t_regs;
    wr_mode(8'hA5); chk("R1 readback", reg_rdata_o, 8'hA5);
    wr_mode(8'h5A); chk("R1 readback", reg_rdata_o, 8'h5A);
  endtask

  task automatic t_standby;
    wr_mode(8'hFF);
    standby_i = 1'b1; reg_we_i = 1'b1; reg_wdata_i = 8'h77;
    step(1);
    chk("R2 standby clear", reg_rdata_o, 8'h00);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(1);
    t_reset();
    t_regs();
    t_standby();
    run_frame("R3 8N1", 8'h00, 8'h35, 0, 8'h00, 8'h00);
    run_frame("R4 7-bit drop msb", 8'h40, 8'hC3, 0, 8'h00, 8'h00);
    run_frame("R5 even parity", 8'h20, 8'h07, 0, 8'h00, 8'h00);
    run_frame("R5 odd parity", 8'h30, 8'h07, 0, 8'h00, 8'h00);
    run_frame("R4 R5 7-bit parity", 8'h60, 8'h81, 0, 8'h00, 8'h00);
    run_frame("R6 two stop", 8'h08, 8'h9E, 0, 8'h00, 8'h00);
    run_frame("R7 sync", 8'h80, 8'hA6, 0, 8'h00, 8'h00);
    run_frame("R7 sync ignores len/parity", 8'hE8, 8'hB3, 0, 8'h00, 8'h00);
    run_frame("R8 divide 4", 8'h01, 8'h6D, 0, 8'h00, 8'h00);
    run_frame("R8 divide 64", 8'h2B, 8'h1F, 0, 8'h00, 8'h00);
    run_frame("R9 mid-frame write", 8'h00, 8'h5C, 1, 8'hE8, 8'hFF);
    run_frame("R9 after mid write", 8'hE8, 8'hFF, 0, 8'h00, 8'h00);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule